// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh Scheduler

This block connects a simple host request port to a 1M x 1 dynamic memory whose twenty address bits share ten pins. When a host read or write is accepted, the controller sends the address in two halves. The first half goes out with the row strobe, and the second half goes out with the column strobe. The split is uneven. The row strobe carries the nine row bits and also the lowest column bit. The column strobe carries the ten upper address bits. The row strobe also acts as the chip enable, so no separate select pin exists.

Stored charge leaks away, so the controller also runs a refresh scheduler. A timer divides the refresh period, which is a parameter, into 512 equal slots. In each slot the timer asks for one row-only refresh cycle, and a 9-bit row counter supplies the row number. A refresh request that arrives during a host access waits until that access and its precharge are finished. A host request that arrives while a refresh is pending or running is held off through a valid/ready handshake.

Every cycle follows fixed timing rules. The address is held on the pins for a set number of setup cycles before each strobe falls. The row strobe stays low until the column strobe has returned high. The row strobe then stays high for a precharge time before it can fall again.

Top module: `dram_mux_ctrl`

## Requirements
- R1: In a host access, the pins at the row-strobe fall carry address bits [9:0] (pin 9 = a9, pins 8..0 = a8..a0). At the column-strobe fall they carry address bits [19:10] (pin k = a(k+10)).
- R2: `dram_addr` holds the same value for at least SETUP_CYC clock cycles before each falling edge of `dram_ras_n` and of `dram_cas_n`.
- R3: `dram_cas_n` is low only while `dram_ras_n` is low, and `dram_ras_n` rises only after `dram_cas_n` has been high for at least one cycle.
- R4: After `dram_ras_n` rises, it stays high for at least RP_CYC cycles before it falls again.
- R5: In a write, `dram_we_n` is low and `dram_dout` equals the write data at the column-strobe fall. A read returns `dram_din`, sampled at the end of the column-strobe phase, on `rsp_rdata` with a one-cycle `rsp_valid` pulse. `dram_we_n` is low only while `dram_ras_n` is low.
- R6: A refresh is row-strobe only: `dram_cas_n` stays high, and the pins carry {1'b0, row counter[8:0]}. The counter starts at 0, advances by one after each refresh, and wraps from 511 to 0.
- R7: One refresh is requested every REFRESH_MS*CLK_KHZ/512 cycles, so all 512 rows are covered within the refresh period (default 4 ms).
- R8: `req_ready` is high only while the controller is idle with no refresh pending. A request held on `req_valid` while `req_ready` is low is served later, unchanged and exactly once.
- R9: A refresh that becomes due during a host access starts only after that access and its precharge have ended, and before any further host request is accepted.
- R10: After reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Host bit address |
| req_wdata | input | 1 | Write data bit |
| req_ready | output | 1 | Request accepted on a clock edge where valid and ready are both high |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 1 | Read data bit |
| dram_ras_n | output | 1 | Row strobe and chip enable, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 10 | Shared multiplexed address pins |
| dram_dout | output | 1 | Data bit driven to the memory |
| dram_din | input | 1 | Data bit returned by the memory |

## Verification
The checker tests the strobe rules on every cycle: column strobe only inside row strobe, the order in which the strobes release, address stability at each strobe fall, the minimum precharge time, write enable only inside a row cycle, and the ready signal being off whenever a refresh is pending. The bench scenarios are needed for the rest. Only they can show that the address bits land in the right row and column positions, that written data reads back, and that requests stalled behind refresh are served exactly once. They also show that refresh rows run in sequence and wrap past 511, and that the refresh rate keeps up under heavy host traffic.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW_SETUP,
        ST_RAS_ACT,
        ST_COL_SETUP,
        ST_CAS_ACT,
        ST_CAS_END,
        ST_PRECH,
        ST_REF_SETUP,
        ST_REF_RAS
    } dmc_state_e;

    typedef enum logic [1:0] {
        PIN_ROW,
        PIN_COL,
        PIN_REF
    } pin_sel_e;
endpackage

// File: rtl/dmc_refresh_timer.sv
module dmc_refresh_timer #(
    parameter int INTERVAL = 976,
    parameter int ROW_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_take,
    input  logic             ref_done,
    output logic             ref_pend,
    output logic [ROW_W-1:0] ref_row
);
    localparam int TICK_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic              pend;
        logic [ROW_W-1:0]  row;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.tick == '0) begin
            tmr_d.tick = TICK_W'(INTERVAL - 1);
            tmr_d.pend = 1'b1;
        end else begin
            tmr_d.tick = tmr_q.tick - 1'b1;
            if (ref_take) tmr_d.pend = 1'b0;
        end
        if (ref_done) tmr_d.row = tmr_q.row + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.tick <= TICK_W'(INTERVAL - 1);
            tmr_q.pend <= 1'b0;
            tmr_q.row  <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign ref_pend = tmr_q.pend;
    assign ref_row  = tmr_q.row;
endmodule

// File: rtl/dmc_addr_mux.sv
module dmc_addr_mux
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int PIN_W  = 10,
    parameter int ROW_W  = 9
) (
    input  pin_sel_e          sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ROW_W-1:0]  ref_row,
    output logic [PIN_W-1:0]  pins
);
    // Row phase also carries the lowest column bit above the row field.
    always_comb begin
        unique case (sel)
            PIN_COL: pins = addr[ADDR_W-1:PIN_W];
            PIN_REF: pins = {{(PIN_W-ROW_W){1'b0}}, ref_row};
            default: pins = addr[PIN_W-1:0];
        endcase
    end
endmodule

// File: rtl/dmc_strobe_dec.sv
module dmc_strobe_dec
    import dmc_pkg::*;
(
    input  dmc_state_e st,
    input  logic       wr,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output pin_sel_e   sel
);
    always_comb begin
        ras_n = !(st inside {ST_RAS_ACT, ST_COL_SETUP, ST_CAS_ACT, ST_CAS_END, ST_REF_RAS});
        cas_n = (st != ST_CAS_ACT);
        we_n  = !(wr && (st inside {ST_COL_SETUP, ST_CAS_ACT}));
        if (st inside {ST_COL_SETUP, ST_CAS_ACT, ST_CAS_END})
            sel = PIN_COL;
        else if (st inside {ST_REF_SETUP, ST_REF_RAS})
            sel = PIN_REF;
        else
            sel = PIN_ROW;
    end
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int ROW_W       = 9,
    parameter int SETUP_CYC   = 2,
    parameter int RCD_CYC     = 2,
    parameter int CAS_CYC     = 2,
    parameter int RP_CYC      = 3,
    parameter int REF_RAS_CYC = 4,
    parameter int REFRESH_MS  = 4,
    parameter int CLK_KHZ     = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_rdata,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [ADDR_W/2-1:0] dram_addr,
    output logic              dram_dout,
    input  logic              dram_din
);
    localparam int PIN_W        = ADDR_W / 2;
    localparam int ROWS         = 1 << ROW_W;
    localparam int REF_INTERVAL = (REFRESH_MS * CLK_KHZ) / ROWS;
    localparam int CNT_W        = $clog2(SETUP_CYC + RCD_CYC + CAS_CYC + RP_CYC + REF_RAS_CYC + 1);

    typedef struct packed {
        dmc_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              wdata;
        logic              rsp_valid;
        logic              rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             ref_pend;
    logic [ROW_W-1:0] ref_row;
    logic             ref_take;
    logic             ref_done;
    logic             cnt_zero;
    pin_sel_e         pin_sel;

    assign cnt_zero = (ctl_q.cnt == '0);
    assign ref_take = (ctl_q.st == ST_IDLE) && ref_pend;
    assign ref_done = (ctl_q.st == ST_REF_RAS) && cnt_zero;

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        if (!cnt_zero) ctl_d.cnt = ctl_q.cnt - 1'b1;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    ctl_d.st  = ST_REF_SETUP;
                    ctl_d.cnt = CNT_W'(SETUP_CYC - 1);
                end else if (req_valid) begin
                    ctl_d.st    = ST_ROW_SETUP;
                    ctl_d.cnt   = CNT_W'(SETUP_CYC - 1);
                    ctl_d.addr  = req_addr;
                    ctl_d.wr    = req_write;
                    ctl_d.wdata = req_wdata;
                end
            end
            ST_ROW_SETUP: if (cnt_zero) begin
                ctl_d.st  = ST_RAS_ACT;
                ctl_d.cnt = CNT_W'(RCD_CYC - 1);
            end
            ST_RAS_ACT: if (cnt_zero) begin
                ctl_d.st  = ST_COL_SETUP;
                ctl_d.cnt = CNT_W'(SETUP_CYC - 1);
            end
            ST_COL_SETUP: if (cnt_zero) begin
                ctl_d.st  = ST_CAS_ACT;
                ctl_d.cnt = CNT_W'(CAS_CYC - 1);
            end
            ST_CAS_ACT: if (cnt_zero) begin
                ctl_d.st = ST_CAS_END;
                if (!ctl_q.wr) begin
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rdata     = dram_din;
                end
            end
            ST_CAS_END: begin
                ctl_d.st  = ST_PRECH;
                ctl_d.cnt = CNT_W'(RP_CYC - 1);
            end
            ST_PRECH: if (cnt_zero) ctl_d.st = ST_IDLE;
            ST_REF_SETUP: if (cnt_zero) begin
                ctl_d.st  = ST_REF_RAS;
                ctl_d.cnt = CNT_W'(REF_RAS_CYC - 1);
            end
            ST_REF_RAS: if (cnt_zero) begin
                ctl_d.st  = ST_PRECH;
                ctl_d.cnt = CNT_W'(RP_CYC - 1);
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st        <= ST_IDLE;
            ctl_q.cnt       <= '0;
            ctl_q.addr      <= '0;
            ctl_q.wr        <= 1'b0;
            ctl_q.wdata     <= 1'b0;
            ctl_q.rsp_valid <= 1'b0;
            ctl_q.rdata     <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dmc_refresh_timer #(
        .INTERVAL (REF_INTERVAL),
        .ROW_W    (ROW_W)
    ) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_take (ref_take),
        .ref_done (ref_done),
        .ref_pend (ref_pend),
        .ref_row  (ref_row)
    );

    dmc_strobe_dec dec_i (
        .st    (ctl_q.st),
        .wr    (ctl_q.wr),
        .ras_n (dram_ras_n),
        .cas_n (dram_cas_n),
        .we_n  (dram_we_n),
        .sel   (pin_sel)
    );

    dmc_addr_mux #(
        .ADDR_W (ADDR_W),
        .PIN_W  (PIN_W),
        .ROW_W  (ROW_W)
    ) mux_i (
        .sel     (pin_sel),
        .addr    (ctl_q.addr),
        .ref_row (ref_row),
        .pins    (dram_addr)
    );

    assign req_ready = (ctl_q.st == ST_IDLE) && !ref_pend;
    assign rsp_valid = ctl_q.rsp_valid;
    assign rsp_rdata = ctl_q.rdata;
    assign dram_dout = ctl_q.wdata;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int PIN_W  = 10,
    parameter int RP_CYC = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [PIN_W-1:0] pins,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             ref_pend
);
    localparam int HC_W = $clog2(RP_CYC + 2);

    logic [HC_W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= HC_W'(RP_CYC);
        else if (!ras_n)
            hi_cnt <= '0;
        else if (hi_cnt < HC_W'(RP_CYC))
            hi_cnt <= hi_cnt + 1'b1;
    end

    p_cas_inside_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);
    p_ras_release_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> $past(cas_n));
    p_row_addr_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(pins));
    p_col_addr_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(pins));
    p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= HC_W'(RP_CYC)));
    p_we_inside_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ras_n);
    p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ras_n && cas_n));
    p_refresh_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);
endmodule

bind dram_mux_ctrl dmc_checker #(
    .PIN_W  (ADDR_W / 2),
    .RP_CYC (RP_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .pins      (dram_addr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ref_pend  (ref_pend)
);

// File: tb/dram_mux_ctrl_tb_top.sv
module dram_mux_ctrl_tb_top;
    localparam int SETUP = 2;
    localparam int RP    = 3;
    localparam int KHZ   = 8000;
    localparam int INTV  = (4 * KHZ) / 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_rdata;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dout;
    logic        dram_din = 1'b0;
    logic [9:0]  dram_addr;

    always #4 clk = ~clk;

    dram_mux_ctrl #(.CLK_KHZ(KHZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr),
        .dram_dout(dram_dout), .dram_din(dram_din)
    );

    typedef struct {
        logic [19:0] a;
        logic        w;
        logic        d;
    } acc_t;

    acc_t acc_q[$];
    logic rd_q[$];
    bit   sh  [bit [19:0]];
    bit   mem [bit [19:0]];

    int checks = 0, fails = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: pushes expected items, then presents the request until accepted.
    task automatic host_op(input logic w, input logic [19:0] a, input logic d);
        acc_t e;
        e.a = a; e.w = w; e.d = d;
        acc_q.push_back(e);
        if (w) sh[a] = d;
        else rd_q.push_back(sh.exists(a) ? sh[a] : 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Memory model and monitor
    logic        prev_ras = 1'b1, prev_cas = 1'b1;
    logic [9:0]  prev_addr = '0, row_pins = '0;
    int          stab = 0, hicnt = 100;
    bit          cas_seen = 0, wrap_seen = 0;
    logic [8:0]  ref_exp = '0;
    int          ref_cnt = 0, busy_ready = 0;
    bit [19:0]   cur_a = '0;

    always @(posedge clk) cyc++;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (!dram_ras_n && prev_ras) begin
                    chk(dram_addr == prev_addr && stab >= SETUP, "R2 row setup", stab, SETUP);
                    chk(hicnt >= RP, "R4 precharge", hicnt, RP);
                    row_pins = dram_addr;
                    cas_seen = 0;
                end
                if (!dram_cas_n && prev_cas) begin
                    acc_t e;
                    chk(dram_addr == prev_addr && stab >= SETUP, "R2 col setup", stab, SETUP);
                    cas_seen = 1;
                    cur_a = {dram_addr, row_pins};
                    if (acc_q.size() == 0) begin
                        chk(0, "R1 unexpected access", cur_a, 0);
                    end else begin
                        e = acc_q.pop_front();
                        chk(row_pins == e.a[9:0], "R1 row phase pins", row_pins, e.a[9:0]);
                        chk(dram_addr == e.a[19:10], "R1 col phase pins", dram_addr, e.a[19:10]);
                        chk(dram_we_n == !e.w, "R5 write enable", dram_we_n, !e.w);
                        if (e.w) chk(dram_dout == e.d, "R5 write data", dram_dout, e.d);
                    end
                    if (!dram_we_n) mem[cur_a] = dram_dout;
                end
                if (!dram_cas_n) dram_din = mem.exists(cur_a) ? mem[cur_a] : 1'b0;
                if (dram_ras_n && !prev_ras && !cas_seen) begin
                    chk(row_pins == {1'b0, ref_exp}, "R6 refresh row", row_pins, {1'b0, ref_exp});
                    if (ref_exp == 9'd511) wrap_seen = 1;
                    ref_exp = ref_exp + 1'b1;
                    ref_cnt++;
                end
                if (!dram_ras_n && req_ready) busy_ready++;
                if (rsp_valid) begin
                    if (rd_q.size() == 0) chk(0, "R5 unexpected response", rsp_rdata, 0);
                    else begin
                        logic x;
                        x = rd_q.pop_front();
                        chk(rsp_rdata == x, "R5 read data", rsp_rdata, x);
                    end
                end
                stab  = (dram_addr == prev_addr) ? stab + 1 : 1;
                hicnt = dram_ras_n ? hicnt + 1 : 0;
                prev_ras  = dram_ras_n;
                prev_cas  = dram_cas_n;
                prev_addr = dram_addr;
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            finish_run();
        end
    end

    initial begin
        int c0, r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R10 strobes idle", {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
        chk(!rsp_valid, "R10 rsp_valid low", rsp_valid, 0);
        chk(req_ready, "R10 ready high", req_ready, 1);

        // Directed patterns: a9 alone, all ones, upper half only, alternating
        host_op(1, 20'h00200, 1);
        host_op(1, 20'hFFFFF, 1);
        host_op(1, 20'hFFC00, 1);
        host_op(1, 20'hAAAAA, 1);
        host_op(1, 20'h55555, 0);
        host_op(0, 20'h00200, 0);
        host_op(0, 20'h00000, 0);
        host_op(0, 20'hFFFFF, 0);
        host_op(0, 20'hFFC00, 0);
        host_op(0, 20'hAAAAA, 0);
        host_op(0, 20'h55555, 0);

        // Back-to-back traffic colliding with refresh (R8, R9)
        c0 = cyc; r0 = ref_cnt;
        for (int i = 0; i < 150; i++) host_op(1, 20'(i * 647567 + 341), 1'(i ^ (i >> 2)));
        for (int i = 0; i < 150; i++) host_op(0, 20'(i * 647567 + 341), 1'b0);
        repeat (30) @(negedge clk);
        chk(ref_cnt - r0 >= (cyc - c0) / INTV - 2, "R9 refresh keeps up under traffic", ref_cnt - r0, (cyc - c0) / INTV - 2);
        chk(acc_q.size() == 0 && rd_q.size() == 0, "R8 all stalled requests served", acc_q.size() + rd_q.size(), 0);
        chk(busy_ready == 0, "R8 ready low while busy", busy_ready, 0);

        // Idle until the row counter wraps (R6, R7)
        c0 = cyc; r0 = ref_cnt;
        while (!wrap_seen || ref_exp < 9'd3) @(negedge clk);
        chk(wrap_seen, "R6 counter wrap 511 to 0", wrap_seen, 1);
        chk(ref_cnt - r0 >= (cyc - c0) / INTV - 1, "R7 refresh rate", ref_cnt - r0, (cyc - c0) / INTV - 1);
        chk(ref_cnt - r0 <= (cyc - c0) / INTV + 1, "R7 refresh not too frequent", ref_cnt - r0, (cyc - c0) / INTV + 1);

        // Final read-back after many refreshes
        host_op(0, 20'hFFFFF, 0);
        host_op(0, 20'h00200, 0);
        repeat (40) @(negedge clk);
        chk(acc_q.size() == 0 && rd_q.size() == 0, "R5 final responses", acc_q.size() + rd_q.size(), 0);
        finished = 1;
        finish_run();
    end
endmodule